// File: doc/BRIEF.md
# Serial Start Pattern Detector

This block sits behind a bit-rate demodulator and looks for a programmed start pattern in the incoming serial stream. Every received bit is shifted into a history register. The most recent 8, 16, 24 or 32 bits are compared with the programmed pattern on each bit period. A frame on the air is a 24-bit preamble, then the start pattern, then payload. When the pattern is found, the block does three things:

- It raises a detect pulse for one bit period.
- It sets a sticky flag.
- It starts packing the following payload bits into bytes for a receive FIFO.

The preamble and pattern bits are never passed on.

While the sticky flag is set, the comparator stays dormant. The host clears the flag with a clear strobe. That strobe also stops filling, drops any partial byte and re-arms the search. A fill-mode input lets the host start filling on its own by setting the flag, without waiting for a match. A one-bit select routes either the detect pulse or the byte strobe to an interrupt output.

Top module: `sync_hunter`

## Requirements
- R1: On each clock with `bit_en` high, `bit_in` is shifted in at bit 0 of a history register. The newest (PAT_LEN+1)*8 history bits, newest at bit 0, are compared with the same low bits of `pattern`, where PAT_LEN is the value of `pat_len`. `pattern` bits above that length are ignored.
- R2: `det_pulse` goes high on the clock after the `bit_en` cycle that completes a match. It stays high until the clock after the next `bit_en` cycle, which is exactly one bit period.
- R3: A match sets `sync_flag`. While `sync_flag` is set, no further match is taken and `det_pulse` does not rise again.
- R4: A `host_clr` cycle clears `sync_flag`, stops filling, discards any partial byte and re-arms matching from the next bit. If `host_clr` and `host_set` arrive in the same cycle, the clear wins.
- R5: With `fill_mode` = 0, filling starts with the first bit after the last pattern bit, so preamble and pattern bits are never written. In this mode `host_set` sets `sync_flag` only and starts no filling.
- R6: With `fill_mode` = 1, a `host_set` cycle sets `sync_flag` and starts filling from the next bit. A pattern match alone does not start filling in this mode.
- R7: Payload bits are packed MSB first; the first bit after filling starts becomes bit 7. `byte_wr` is high for one clock, on the clock after the `bit_en` of each 8th bit, with the byte on `byte_out`.
- R8: `irq_out` follows `det_pulse` when `irq_sel` = 1 and follows `byte_wr` when `irq_sel` = 0.
- R9: A synchronous reset (`rst` high at a clock edge) clears the history, `sync_flag`, the fill state, the bit counter, `det_pulse`, `byte_wr` and `byte_out`, and leaves matching armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-clock strobe marking a received bit |
| bit_in | input | 1 | Received data bit |
| pattern | input | PAT_W | Start pattern, last bit on air at bit 0 |
| pat_len | input | clog2(PAT_W/8) | Pattern length in bytes minus one |
| fill_mode | input | 1 | 0: fill after match, 1: fill after host set |
| host_set | input | 1 | Host writes 1 to the sticky flag |
| host_clr | input | 1 | Host clears the flag and restarts search |
| irq_sel | input | 1 | Interrupt routing select |
| det_pulse | output | 1 | One-bit-period detect pulse |
| sync_flag | output | 1 | Sticky start-detect flag |
| byte_out | output | 8 | Assembled payload byte |
| byte_wr | output | 1 | FIFO write strobe |
| irq_out | output | 1 | Routed interrupt |

## Verification
Every result is one register behind its cause. `det_pulse` and `sync_flag` change on the clock after the `bit_en` of the matching bit. `byte_wr` and `byte_out` change on the clock after the `bit_en` of the 8th bit, and the flag responds one clock after a host strobe. The bench drives inputs and samples outputs on the falling edge. It leaves at least one idle clock after each bit, so every sample falls after the register that produces it. Pulse width is counted in falling-edge samples and compared with the idle gap plus one, which checks that the pulse lasts exactly one bit period.

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int PAT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                bit_en,
  input  logic                                bit_in,
  input  logic [PAT_W-1:0]                    pattern,
  input  logic [$clog2(PAT_W/BYTE_W)-1:0]     pat_len,
  input  logic                                fill_mode,
  input  logic                                host_set,
  input  logic                                host_clr,
  input  logic                                irq_sel,
  output logic                                det_pulse,
  output logic                                sync_flag,
  output logic [BYTE_W-1:0]                   byte_out,
  output logic                                byte_wr,
  output logic                                irq_out
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [PAT_W-1:0]  hist_q;
  logic [PAT_W-1:0]  hist_d;
  logic [PAT_W-1:0]  cmp_mask;
  logic [BYTE_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fill_q;
  logic              hit;
  logic              byte_done;

  assign hist_d = {hist_q[PAT_W-2:0], bit_in};

  always_comb begin
    cmp_mask = '0;
    for (int i = 0; i < PAT_W; i++)
      if (i < (int'(pat_len) + 1) * BYTE_W) cmp_mask[i] = 1'b1;
  end

  assign hit       = bit_en && !sync_flag && (((hist_d ^ pattern) & cmp_mask) == '0);
  assign byte_done = fill_q && bit_en && (cnt_q == CNT_W'(BYTE_W - 1)) && !host_clr;
  assign irq_out   = irq_sel ? det_pulse : byte_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      det_pulse <= 1'b0;
      sync_flag <= 1'b0;
      fill_q    <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      byte_out  <= '0;
      byte_wr   <= 1'b0;
    end else begin
      if (bit_en) hist_q <= hist_d;

      if (hit)         det_pulse <= 1'b1;
      else if (bit_en) det_pulse <= 1'b0;

      if (host_clr)             sync_flag <= 1'b0;
      else if (hit || host_set) sync_flag <= 1'b1;

      if (host_clr)                        fill_q <= 1'b0;
      else if (hit && !fill_mode)          fill_q <= 1'b1;
      else if (host_set && fill_mode)      fill_q <= 1'b1;

      if (host_clr) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (fill_q && bit_en) begin
        acc_q <= {acc_q[BYTE_W-2:0], bit_in};
        cnt_q <= cnt_q + 1'b1;
      end

      byte_wr <= byte_done;
      if (byte_done) byte_out <= {acc_q[BYTE_W-2:0], bit_in};
    end
  end

  AST_PULSE_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(det_pulse) |-> !$past(sync_flag));  // R3
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(det_pulse) && !$past(host_clr) |-> sync_flag);  // R2
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    det_pulse && !bit_en |=> det_pulse);  // R2
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    det_pulse && bit_en && sync_flag |=> !det_pulse);  // R2
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_wr |=> !byte_wr);  // R7
  AST_WR_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    byte_wr |-> $past(fill_q) && $past(bit_en));  // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    host_clr |=> !sync_flag && !byte_wr);  // R4
  AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (rst)
    irq_out == (irq_sel ? det_pulse : byte_wr));  // R8
endmodule

// File: tb/sync_hunter_bench.sv
module sync_hunter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0, bit_in = 1'b0;
  logic [31:0] pattern = '0;
  logic [1:0]  pat_len = '0;
  logic        fill_mode = 1'b0, host_set = 1'b0, host_clr = 1'b0, irq_sel = 1'b0;
  logic        det_pulse, sync_flag, byte_wr, irq_out;
  logic [7:0]  byte_out;

  int checks = 0, fails = 0;
  int got_n = 0, pulse_cnt = 0, pulse_cyc = 0, irq_bad = 0;
  int gap = 1;
  logic [7:0] got [0:255];
  logic [7:0] exp_b [0:255];
  logic det_q = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_hunter u_sync_hunter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .pattern(pattern),
    .pat_len(pat_len), .fill_mode(fill_mode), .host_set(host_set), .host_clr(host_clr),
    .irq_sel(irq_sel), .det_pulse(det_pulse), .sync_flag(sync_flag),
    .byte_out(byte_out), .byte_wr(byte_wr), .irq_out(irq_out));

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_wr && got_n < 256) begin got[got_n] = byte_out; got_n++; end
      if (det_pulse) pulse_cyc++;
      if (det_pulse && !det_q) pulse_cnt++;
      if (irq_out !== (irq_sel ? det_pulse : byte_wr)) irq_bad++;
    end
    det_q = rst ? 1'b0 : det_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pat_for(input int len);
    case (len)
      1: pat_for = 32'h0000_00C6;
      2: pat_for = 32'h0000_D391;
      3: pat_for = 32'h00E1_5A3C;
      default: pat_for = 32'hF0C3_96A5;
    endcase
  endfunction

  function automatic logic [31:0] low_mask(input int len);
    low_mask = (len >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * len)) - 1);
  endfunction

  task automatic send_bit(input logic b);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe_clr();
    host_clr = 1'b1; @(negedge clk); host_clr = 1'b0;
  endtask

  task automatic strobe_set();
    host_set = 1'b1; @(negedge clk); host_set = 1'b0;
  endtask

  task automatic clear_counts();
    got_n = 0; pulse_cnt = 0; pulse_cyc = 0;
  endtask

  task automatic send_preamble();
    for (int i = 0; i < 3; i++) send_byte(8'hAA);
  endtask

  task automatic run_frame(input int len, input int npay, input bit pat_in_pay);
    logic [31:0] p;
    p = pat_for(len);
    pattern = p | ($urandom & ~low_mask(len));
    pat_len = 2'(len - 1);
    for (int i = 0; i < npay; i++) exp_b[i] = 8'($urandom);
    if (pat_in_pay)
      for (int i = 0; i < len && i < npay; i++) exp_b[i] = p[8*(len-1-i) +: 8];
    clear_counts();
    send_preamble();
    chk(pulse_cnt == 0, "R1 no match in preamble", pulse_cnt, 0);
    for (int i = len - 1; i >= 0; i--) send_byte(p[8*i +: 8]);
    chk(pulse_cnt == 1 && sync_flag, "R3 match sets flag", pulse_cnt, 1);
    for (int i = 0; i < npay; i++) send_byte(exp_b[i]);
    chk(pulse_cyc == gap + 1, "R2 pulse lasts one bit period", pulse_cyc, gap + 1);
    chk(got_n == npay, "R5 only payload bytes written", got_n, npay);
    for (int i = 0; i < npay && i < got_n; i++)
      chk(got[i] == exp_b[i], "R7 byte MSB first", int'(got[i]), int'(exp_b[i]));
    if (pat_in_pay) chk(pulse_cnt == 1, "R3 dormant while flag set", pulse_cnt, 1);
    strobe_clr();
    chk(!sync_flag, "R4 clear drops flag", int'(sync_flag), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!det_pulse && !sync_flag && !byte_wr && byte_out == 8'h00, "R9 reset state",
        int'({det_pulse, sync_flag, byte_wr}), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int len = 1; len <= 4; len++) begin
      gap = 1 + int'($urandom % 3); irq_sel = 1'($urandom);
      run_frame(len, 3, 1'b0);
    end
    gap = 2; irq_sel = 1'b1;
    run_frame(2, 4, 1'b1);
    run_frame(4, 5, 1'b1);
    for (int k = 0; k < 6; k++) begin
      gap = 1 + int'($urandom % 4); irq_sel = 1'($urandom);
      run_frame(1 + int'($urandom % 4), 1 + int'($urandom % 6), 1'($urandom));
    end

    // R4: clear during fill discards partial byte and re-arms
    gap = 1; pattern = pat_for(2); pat_len = 2'd1; clear_counts();
    send_preamble(); send_byte(8'hD3); send_byte(8'h91);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    strobe_clr();
    send_byte(8'h5C);
    chk(got_n == 0, "R4 partial byte dropped, fill stopped", got_n, 0);
    send_preamble(); send_byte(8'hD3); send_byte(8'h91); send_byte(8'h3B);
    chk(pulse_cnt == 2, "R4 matching re-armed", pulse_cnt, 2);
    chk(got_n == 1 && got[0] == 8'h3B, "R4 fill restarts cleanly", got_n, 1);
    strobe_clr();

    // R4: clear beats set in the same cycle
    host_set = 1'b1; host_clr = 1'b1; @(negedge clk); host_set = 1'b0; host_clr = 1'b0;
    chk(!sync_flag, "R4 clear wins over set", int'(sync_flag), 0);

    // R5: host set in mode 0 sets flag, no filling, no detection
    clear_counts(); fill_mode = 1'b0;
    strobe_set();
    chk(sync_flag, "R5 host set raises flag", int'(sync_flag), 1);
    send_preamble(); send_byte(8'hD3); send_byte(8'h91); send_byte(8'h77);
    chk(got_n == 0 && pulse_cnt == 0, "R5 mode 0 set starts no fill", got_n + pulse_cnt, 0);
    strobe_clr();

    // R6: mode 1, host set starts filling without pattern
    fill_mode = 1'b1; clear_counts();
    send_preamble(); send_byte(8'hD3); send_byte(8'h91); send_byte(8'h44);
    chk(got_n == 0 && pulse_cnt == 1, "R6 match alone starts no fill", got_n, 0);
    strobe_clr(); clear_counts();
    send_byte(8'h00);
    strobe_set();
    chk(sync_flag && pulse_cnt == 0, "R6 set raises flag, no pulse", pulse_cnt, 0);
    send_byte(8'hE7); send_byte(8'h18);
    chk(got_n == 2 && got[0] == 8'hE7 && got[1] == 8'h18, "R6 fill from next bit", got_n, 2);
    strobe_clr(); fill_mode = 1'b0;

    // R9: reset in the middle of a fill
    clear_counts(); send_preamble(); send_byte(8'hD3); send_byte(8'h91);
    send_bit(1'b1); send_bit(1'b1);
    rst = 1'b1; @(negedge clk);
    chk(!sync_flag && !det_pulse && !byte_wr, "R9 reset mid fill", int'(sync_flag), 0);
    rst = 1'b0; @(negedge clk); clear_counts();
    send_byte(8'h12);
    chk(got_n == 0, "R9 fill stopped by reset", got_n, 0);
    send_preamble(); send_byte(8'hD3); send_byte(8'h91); send_byte(8'hA9);
    chk(pulse_cnt == 1 && got_n == 1 && got[0] == 8'hA9, "R9 armed after reset", got_n, 1);
    strobe_clr();

    chk(irq_bad == 0, "R8 irq routing", irq_bad, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule